// File: doc/BRIEF.md
# Card I/O Read Target

This block answers host I/O read cycles on a memory-card style bus, with every timing counted in system clock cycles. The host strobes (card enable, register select and I/O read, all active low) pass through two-flop synchronizers, and the block detects strobe edges in the system clock domain. A read strobe that falls while the card is selected starts a cycle. The block then asserts the input-acknowledge output, drives the data bus and holds the host with an active-low WAIT. At the same time it sends a single-cycle read request carrying the latched address to an internal memory port.

WAIT stays low until that port returns a done pulse with the data. The data is placed on the host bus in the same clock edge that releases WAIT. If the internal arbitration takes too long, WAIT is released after a bounded number of cycles and the bus reads all ones. When the read strobe rises, the acknowledge is withdrawn and the bus driver is turned off.

Top module: `card_ioread_target`

## Requirements
- R1: After reset, ack_n and wait_n are 1, data_oe and rd_req are 0 and data_o is 0.
- R2: When host_iord_n falls while host_ce_n and host_reg_n are both low, the outputs change on the third rising clock edge after the fall: ack_n goes to 0, wait_n goes to 0 and data_oe goes to 1.
- R3: A falling read strobe is ignored when host_ce_n is high or host_reg_n is high. In that case no rd_req is issued, ack_n and wait_n stay 1, and data_oe stays 0.
- R4: Each qualified cycle raises rd_req for exactly one clock, in the same edge as R2. During that clock rd_addr equals host_addr.
- R5: While wait_n is 0, data_o is all zeros. rd_done sampled high during the wait releases wait_n in the next edge, and data_o shows the rd_data sampled with it in that same edge.
- R6: wait_n is never low for more than MAX_WAIT (default 53) consecutive cycles. If no rd_done arrives within that time, wait_n rises and data_o becomes all ones.
- R7: When host_iord_n rises after a cycle, ack_n returns to 1, data_oe returns to 0 and data_o returns to 0, on the third edge after the rise.
- R8: rd_done arriving after wait_n has been released has no effect on data_o.
- R9: If the read strobe rises while wait_n is low, the cycle is abandoned: the outputs return to the R1 idle values and no further rd_req is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | AW | Host address, stable before the strobe falls |
| host_reg_n | input | 1 | Register-space select, active low |
| host_ce_n | input | 1 | Card enable, active low |
| host_iord_n | input | 1 | I/O read strobe, active low |
| ack_n | output | 1 | Input acknowledge, active low |
| wait_n | output | 1 | Cycle stretch, active low |
| data_oe | output | 1 | Host data bus output enable |
| data_o | output | DW | Host data bus value |
| rd_req | output | 1 | Single-cycle internal read request |
| rd_addr | output | AW | Address latched for the internal read |
| rd_done | input | 1 | Internal read completion pulse |
| rd_data | input | DW | Internal read data, valid with rd_done |

## Verification
The assertions check on every cycle that the request lasts one clock and falls inside a cycle. They also check that the data bus holds zeros while WAIT is low, that a release caused by completion presents the returned word, that WAIT never exceeds its bound, and that the bus is quiet whenever the acknowledge is off. Only the bench scenarios can show the exact three-edge latency through the synchronizers, the rejection of strobes without card enable or register select, the all-ones result of a timeout, the indifference to late completions and an abandoned cycle.

// File: rtl/card_ioread_target.sv
module card_ioread_target #(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 53,
  localparam int CW      = $clog2(MAX_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_reg_n,
  input  logic          host_ce_n,
  input  logic          host_iord_n,
  output logic          ack_n,
  output logic          wait_n,
  output logic          data_oe,
  output logic [DW-1:0] data_o,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} state_t;

  state_t        st;
  logic [1:0]    iord_sy, ce_sy, reg_sy;
  logic          iord_d;
  logic [CW-1:0] wcnt;

  wire strobe_fall = iord_d & ~iord_sy[1];
  wire strobe_rise = ~iord_d & iord_sy[1];
  wire selected    = ~ce_sy[1] & ~reg_sy[1];
  wire limit_hit   = (wcnt == CW'(MAX_WAIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iord_sy <= 2'b11;
      ce_sy   <= 2'b11;
      reg_sy  <= 2'b11;
      iord_d  <= 1'b1;
    end else begin
      iord_sy <= {iord_sy[0], host_iord_n};
      ce_sy   <= {ce_sy[0], host_ce_n};
      reg_sy  <= {reg_sy[0], host_reg_n};
      iord_d  <= iord_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ack_n   <= 1'b1;
      wait_n  <= 1'b1;
      data_oe <= 1'b0;
      data_o  <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wcnt    <= '0;
    end else begin
      rd_req <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (strobe_fall && selected) begin
            st      <= ST_WAIT;
            ack_n   <= 1'b0;
            wait_n  <= 1'b0;
            data_oe <= 1'b1;
            data_o  <= '0;
            rd_req  <= 1'b1;
            rd_addr <= host_addr;
            wcnt    <= '0;
          end
        end
        ST_WAIT: begin
          if (strobe_rise) begin
            st      <= ST_IDLE;
            ack_n   <= 1'b1;
            wait_n  <= 1'b1;
            data_oe <= 1'b0;
            data_o  <= '0;
          end else if (rd_done) begin
            st     <= ST_HOLD;
            wait_n <= 1'b1;
            data_o <= rd_data;
          end else if (limit_hit) begin
            st     <= ST_HOLD;
            wait_n <= 1'b1;
            data_o <= '1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (strobe_rise) begin
            st      <= ST_IDLE;
            ack_n   <= 1'b1;
            data_oe <= 1'b0;
            data_o  <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

module card_ioread_target_chk #(
  parameter int DW       = 8,
  parameter int MAX_WAIT = 53,
  localparam int CW      = $clog2(MAX_WAIT + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_n,
  input logic          wait_n,
  input logic          data_oe,
  input logic [DW-1:0] data_o,
  input logic          rd_req,
  input logic          rd_done,
  input logic [DW-1:0] rd_data
);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (wait_n) low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R4
  AST_REQ_IN_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (!ack_n && !wait_n && data_oe)); // R2
  AST_WAIT_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n) !wait_n |-> (data_o == '0)); // R5
  AST_RELEASE_DATA:  assert property (@(posedge clk) disable iff (!rst_n)
                       ($rose(wait_n) && data_oe && $past(rd_done)) |-> (data_o == $past(rd_data))); // R5
  AST_WAIT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) low_cnt <= CW'(MAX_WAIT)); // R6
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
                       ack_n |-> (!data_oe && wait_n && data_o == '0)); // R7

endmodule

bind card_ioread_target card_ioread_target_chk #(.DW(DW), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .wait_n(wait_n), .data_oe(data_oe),
  .data_o(data_o), .rd_req(rd_req), .rd_done(rd_done), .rd_data(rd_data)
);

// File: tb/card_ioread_target_tb.sv
module card_ioread_target_tb;
  localparam int AW = 10, DW = 8, MAX_WAIT = 53;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic host_reg_n = 1'b1, host_ce_n = 1'b1, host_iord_n = 1'b1;
  logic ack_n, wait_n, data_oe, rd_req;
  logic [DW-1:0] data_o;
  logic [AW-1:0] rd_addr;
  logic rd_done = 1'b0;
  logic [DW-1:0] rd_data = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  card_ioread_target #(.AW(AW), .DW(DW), .MAX_WAIT(MAX_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_reg_n(host_reg_n),
    .host_ce_n(host_ce_n), .host_iord_n(host_iord_n), .ack_n(ack_n), .wait_n(wait_n),
    .data_oe(data_oe), .data_o(data_o), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(ack_n === 1'b1, req, ack_n, 1);
    check(wait_n === 1'b1, req, wait_n, 1);
    check(data_oe === 1'b0, req, data_oe, 0);
    check(data_o === '0, req, data_o, 0);
  endtask

  task automatic start_cycle(input logic [AW-1:0] a);
    host_addr = a; host_ce_n = 1'b0; host_reg_n = 1'b0;
    repeat (3) tick();
    host_iord_n = 1'b0;
    tick(); tick();
    check(ack_n === 1'b1, "R2 not before third edge", ack_n, 1);
    tick();
    check(ack_n === 1'b0 && wait_n === 1'b0 && data_oe === 1'b1, "R2", {ack_n, wait_n, data_oe}, 3'b001);
    check(rd_req === 1'b1, "R4 request", rd_req, 1);
    check(rd_addr === a, "R4 address", rd_addr, a);
    check(data_o === '0, "R5 zero while waiting", data_o, 0);
  endtask

  task automatic end_cycle();
    host_iord_n = 1'b1;
    tick(); tick();
    check(ack_n === 1'b0, "R7 not before third edge", ack_n, 0);
    tick();
    check_idle("R7");
    host_ce_n = 1'b1; host_reg_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    check_idle("R1");
    check(rd_req === 1'b0, "R1 req", rd_req, 0);
  endtask

  task automatic t_normal(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat);
    int low;
    start_cycle(a);
    low = 1;
    for (int i = 0; i < lat; i++) begin
      tick();
      if (i == 0) check(rd_req === 1'b0, "R4 single cycle", rd_req, 0);
      low++;
    end
    rd_done = 1'b1; rd_data = d;
    tick();
    rd_done = 1'b0; rd_data = '0;
    check(wait_n === 1'b1, "R5 release", wait_n, 1);
    check(data_o === d, "R5 data", data_o, d);
    check(low == lat + 1, "R5 wait length", low, lat + 1);
    repeat (2) tick();
    check(data_o === d && data_oe === 1'b1, "R5 data held", data_o, d);
    end_cycle();
  endtask

  task automatic t_ignored(input logic ce, input logic rg);
    bit saw = 0;
    host_addr = 10'h155; host_ce_n = ce; host_reg_n = rg;
    repeat (3) tick();
    host_iord_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (rd_req || !ack_n || !wait_n || data_oe) saw = 1;
    end
    check(!saw, "R3 unselected strobe ignored", saw, 0);
    host_iord_n = 1'b1;
    repeat (4) tick();
    check_idle("R3");
    host_ce_n = 1'b1; host_reg_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_timeout();
    int low = 0;
    start_cycle(10'h2A0);
    while (wait_n === 1'b0 && low < 200) begin
      low++;
      tick();
    end
    check(low == MAX_WAIT, "R6 wait bound", low, MAX_WAIT);
    check(data_o === '1 && data_oe === 1'b1, "R6 all ones", data_o, 8'hFF);
    rd_done = 1'b1; rd_data = 8'h3C;
    tick();
    rd_done = 1'b0; rd_data = '0;
    tick();
    check(data_o === '1, "R8 late done ignored", data_o, 8'hFF);
    end_cycle();
  endtask

  task automatic t_abort();
    bit saw = 0;
    start_cycle(10'h0F0);
    tick();
    host_iord_n = 1'b1;
    tick(); tick(); tick();
    check_idle("R9 abort");
    for (int i = 0; i < 6; i++) begin
      tick();
      if (rd_req) saw = 1;
    end
    check(!saw, "R9 no repeat request", saw, 0);
    check_idle("R9 stays idle");
    host_ce_n = 1'b1; host_reg_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (2) tick();
    t_reset();
    t_normal(10'h123, 8'hA5, 4);
    t_normal(10'h3FF, 8'h5A, 0);
    t_ignored(1'b1, 1'b0);
    t_ignored(1'b0, 1'b1);
    t_timeout();
    t_abort();
    t_normal(10'h001, 8'h81, 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule